// File: doc/BRIEF.md
# Selective-Caching Instruction Cache with Annex Assist

This block is a read-only instruction cache built from two arrays, both looked up in the same cycle. The main array is direct-mapped. The annex is a small set-associative array that sits beside it.

Every line in either array has a tag, a valid bit and a priority bit. The priority bit records recent reuse. A line that hits in the annex is normally handed to the processor straight from the annex, and the main cache is left as it was. The line moves into the main cache only when it has been referenced again before the conflicting main line was used. At that point the two lines trade places. Misses refill the annex, except when the main line at that index is still empty.

The processor side takes one request at a time over a valid/ready handshake and returns a whole line. A line refill port fetches missing lines from the next memory level. Four status strobes tell which path served each request.

Top module: `annex_cache`

## Requirements
- R1: When the request's tag matches the valid main line at its index, the line data is returned 1 cycle after acceptance, with the main-hit strobe. That main line's priority is set, so a later annex hit on a conflicting line is served directly from the annex.
- R2: After reset every line is invalid. A request whose main line is invalid and which misses the annex raises a refill request and puts the returned line into the main cache with priority 0. A repeat of the request then hits in the main cache.
- R3: A request whose main line is valid but holds another tag, and which misses the annex, writes the refill into the annex with priority 1 and clears the main line's priority. As a result, the next request to the same line swaps.
- R4: A main mismatch with main priority 1 and an annex hit is served from the annex 2 cycles after acceptance, with the annex-hit strobe. The arrays do not move the line, the annex line's priority is set and the main priority is cleared.
- R5: A main mismatch with main priority 0 and an annex hit on a line with priority 0 is also a direct annex read, with 2-cycle latency and the annex-hit strobe.
- R6: A main mismatch with main priority 0 and an annex hit on a line with priority 1 swaps the two lines and responds 3 cycles after acceptance, with the swap strobe. The promoted line enters the main cache with priority 1 and the displaced line enters the annex with priority 0. No line is ever held in both arrays.
- R7: An annex refill into a set that has no invalid way replaces the least recently used way of that set. An annex read, an annex fill and a swap each count as a use of the way. The lowest-numbered invalid way is filled first.
- R8: Each response is a one-cycle `rsp_valid` pulse with exactly one of the four status strobes. `req_ready` is low from acceptance until the response.
- R9: On a miss, `mem_req_valid` is held with a line-aligned `mem_req_addr` (offset bits 0) until `mem_rsp_valid`. The response comes in the cycle after the refill data arrives, so with a memory answering 40 cycles after the request it is due 41 cycles after acceptance.
- R10: During and right after reset, `req_ready` is 1 and `rsp_valid`, `mem_req_valid` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor fetch request valid |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | LINE_BYTES*8 | Returned line |
| mem_req_valid | output | 1 | Refill request, held until data returns |
| mem_req_addr | output | ADDR_W | Line-aligned refill address |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | LINE_BYTES*8 | Refill line |
| stat_main_hit | output | 1 | Response served by the main cache |
| stat_annex_hit | output | 1 | Response read directly from the annex |
| stat_swap | output | 1 | Response came with a line moved into the main cache |
| stat_miss | output | 1 | Response came from memory |

## Verification
Latency is counted in rising edges from the edge that accepts a request to the edge that raises `rsp_valid`:
- a main hit is due 1 edge later;
- a direct annex read is due 2 edges later;
- a swap is due 3 edges later;
- a miss is due 41 edges later, with the bench memory answering 40 cycles after it first sees the refill request.

The driver records the accepting cycle and queues the expected path, line data and latency. The monitor samples on falling edges and checks the strobe, the data and the elapsed cycle count against the queued item. Reference sequences of conflicting lines drive each priority path. An eviction series shows which annex way is replaced.

// File: rtl/annex_pkg.sv
package annex_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SWAP,
        ST_ANNEX,
        ST_MEM
    } ctl_state_e;

    typedef enum logic [1:0] {
        ACT_MAIN,
        ACT_ANNEX,
        ACT_SWAP,
        ACT_MISS
    } served_by_e;

endpackage

// File: rtl/annex_lru_set.sv
module annex_lru_set #(
    parameter int WAYS = 4,
    localparam int AW = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    touch_i,
    input  logic [AW-1:0]           touch_way_i,
    output logic [WAYS-1:0][AW-1:0] age_o
);

    logic [WAYS-1:0][AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) age_q[w] <= AW'(w);
        end else if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (AW'(w) == touch_way_i)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way_i])
                    age_q[w] <= age_q[w] + 1'b1;
            end
        end
    end

    assign age_o = age_q;

endmodule

// File: rtl/annex_way_select.sv
module annex_way_select #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    localparam int AW = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]            tag_i,
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0][AW-1:0]     age_i,
    output logic                        hit_o,
    output logic [AW-1:0]               hit_way_o,
    output logic [AW-1:0]               victim_o
);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) hit_way_o = AW'(w);
    end

    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_i[w] == AW'(WAYS - 1)) victim_o = AW'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_i[w]) victim_o = AW'(w);
    end

    assign hit_o = |match;

    // R6: exclusivity keeps at most one way matching
    always_comb begin
        AST_ONE_WAY_MATCH: assert ($countones(match) <= 1 || $isunknown(tag_i)); // R6
    end

endmodule

// File: rtl/annex_cache.sv
module annex_cache
    import annex_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LINE_BYTES   = 32,
    parameter int MAIN_LINES   = 16,
    parameter int ANNEX_WAYS   = 4,
    parameter int ANNEX_BLOCKS = 16,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    output logic              stat_main_hit,
    output logic              stat_annex_hit,
    output logic              stat_swap,
    output logic              stat_miss
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int MIDX_W = $clog2(MAIN_LINES);
    localparam int MTAG_W = LA_W - MIDX_W;
    localparam int ASETS  = ANNEX_BLOCKS / ANNEX_WAYS;
    localparam int AIDX_W = $clog2(ASETS);
    localparam int ATAG_W = LA_W - AIDX_W;
    localparam int WW     = $clog2(ANNEX_WAYS);

    // main array
    logic [MAIN_LINES-1:0] m_valid, m_prio;
    logic [MTAG_W-1:0]     m_tag  [MAIN_LINES];
    logic [LINE_W-1:0]     m_data [MAIN_LINES];
    // annex array
    logic [ANNEX_WAYS-1:0]             a_valid [ASETS];
    logic [ANNEX_WAYS-1:0]             a_prio  [ASETS];
    logic [ANNEX_WAYS-1:0][ATAG_W-1:0] a_tag   [ASETS];
    logic [LINE_W-1:0]                 a_data  [ASETS][ANNEX_WAYS];
    logic [ANNEX_WAYS-1:0][WW-1:0]     age_s   [ASETS];

    ctl_state_e  state;
    served_by_e  act_q;
    logic [LA_W-1:0] la_q;

    wire [MIDX_W-1:0] midx = la_q[MIDX_W-1:0];
    wire [MTAG_W-1:0] mtag = la_q[LA_W-1:MIDX_W];
    wire [AIDX_W-1:0] aset = la_q[AIDX_W-1:0];
    wire [ATAG_W-1:0] atag = la_q[LA_W-1:AIDX_W];

    logic main_valid, main_match, main_p;
    logic a_hit, a_p;
    logic [WW-1:0] hit_way, victim;
    logic [LA_W-1:0] evict_la;
    logic lru_touch;
    logic [WW-1:0] lru_way;

    assign main_valid = m_valid[midx];
    assign main_match = main_valid && (m_tag[midx] == mtag);
    assign main_p     = m_prio[midx];
    assign a_p        = a_prio[aset][hit_way];
    assign evict_la   = {m_tag[midx], midx};

    annex_way_select #(.WAYS(ANNEX_WAYS), .TAG_W(ATAG_W)) u_sel (
        .tag_i    (atag),
        .valid_i  (a_valid[aset]),
        .tags_i   (a_tag[aset]),
        .age_i    (age_s[aset]),
        .hit_o    (a_hit),
        .hit_way_o(hit_way),
        .victim_o (victim)
    );

    assign lru_touch = (state == ST_LOOK && !main_match && a_hit && main_valid)
                    || (state == ST_MEM && mem_rsp_valid && main_valid);
    assign lru_way   = (state == ST_MEM) ? victim : hit_way;

    for (genvar s = 0; s < ASETS; s++) begin : g_lru
        annex_lru_set #(.WAYS(ANNEX_WAYS)) u_lru (
            .clk        (clk),
            .rst        (rst),
            .touch_i    (lru_touch && (aset == AIDX_W'(s))),
            .touch_way_i(lru_way),
            .age_o      (age_s[s])
        );
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_MEM);
    assign mem_req_addr  = {la_q, {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        rsp_valid      <= 1'b0;
        stat_main_hit  <= 1'b0;
        stat_annex_hit <= 1'b0;
        stat_swap      <= 1'b0;
        stat_miss      <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            act_q   <= ACT_MAIN;
            la_q    <= '0;
            m_valid <= '0;
            m_prio  <= '0;
            for (int s = 0; s < ASETS; s++) begin
                a_valid[s] <= '0;
                a_prio[s]  <= '0;
            end
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    la_q  <= req_addr[ADDR_W-1:OFF_W];
                    state <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (main_match) begin
                        m_prio[midx]  <= 1'b1;
                        rsp_data      <= m_data[midx];
                        rsp_valid     <= 1'b1;
                        stat_main_hit <= 1'b1;
                        state         <= ST_IDLE;
                    end else if (a_hit) begin
                        rsp_data <= a_data[aset][hit_way];
                        if (!main_valid) begin
                            // promote into empty main line
                            m_valid[midx] <= 1'b1;
                            m_prio[midx]  <= 1'b1;
                            m_tag[midx]   <= mtag;
                            m_data[midx]  <= a_data[aset][hit_way];
                            a_valid[aset][hit_way] <= 1'b0;
                            act_q <= ACT_SWAP;
                            state <= ST_SWAP;
                        end else if (main_p || !a_p) begin
                            a_prio[aset][hit_way] <= 1'b1;
                            m_prio[midx]          <= 1'b0;
                            act_q <= ACT_ANNEX;
                            state <= ST_ANNEX;
                        end else begin
                            m_prio[midx] <= 1'b1;
                            m_tag[midx]  <= mtag;
                            m_data[midx] <= a_data[aset][hit_way];
                            a_prio[aset][hit_way]  <= 1'b0;
                            a_tag[aset][hit_way]   <= evict_la[LA_W-1:AIDX_W];
                            a_data[aset][hit_way]  <= m_data[midx];
                            act_q <= ACT_SWAP;
                            state <= ST_SWAP;
                        end
                    end else begin
                        act_q <= ACT_MISS;
                        state <= ST_MEM;
                    end
                end
                ST_SWAP: state <= ST_ANNEX;
                ST_ANNEX: begin
                    rsp_valid      <= 1'b1;
                    stat_annex_hit <= (act_q == ACT_ANNEX);
                    stat_swap      <= (act_q == ACT_SWAP);
                    state          <= ST_IDLE;
                end
                ST_MEM: if (mem_rsp_valid) begin
                    rsp_data  <= mem_rsp_data;
                    rsp_valid <= 1'b1;
                    stat_miss <= 1'b1;
                    state     <= ST_IDLE;
                    if (!main_valid) begin
                        m_valid[midx] <= 1'b1;
                        m_prio[midx]  <= 1'b0;
                        m_tag[midx]   <= mtag;
                        m_data[midx]  <= mem_rsp_data;
                    end else begin
                        m_prio[midx]          <= 1'b0;
                        a_valid[aset][victim] <= 1'b1;
                        a_prio[aset][victim]  <= 1'b1;
                        a_tag[aset][victim]   <= atag;
                        a_data[aset][victim]  <= mem_rsp_data;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_MAIN_HIT_NEXT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK && main_match) |=> (rsp_valid && stat_main_hit)); // R1
    AST_ANNEX_READ_TWO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK && !main_match && a_hit && main_valid && (main_p || !a_p))
        |=> !rsp_valid ##1 (rsp_valid && stat_annex_hit)); // R4
    AST_SWAP_THREE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK && !main_match && a_hit && main_valid && !main_p && a_p)
        |=> !rsp_valid ##1 !rsp_valid ##1 (rsp_valid && stat_swap)); // R6
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK) |-> !(main_match && a_hit)); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({stat_main_hit, stat_annex_hit, stat_swap, stat_miss}) == 1)); // R8
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ({stat_main_hit, stat_annex_hit, stat_swap, stat_miss} == 4'b0)); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

endmodule

// File: tb/tb_annex_cache.sv
module tb_annex_cache;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 40;
    localparam int LINE_W     = 256;
    localparam int K_MAIN = 0, K_ANNEX = 1, K_SWAP = 2, K_MISS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic req_ready, rsp_valid, mem_req_valid;
    logic [LINE_W-1:0] rsp_data;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;
    logic stat_main_hit, stat_annex_hit, stat_swap, stat_miss;

    always #(CLK_PERIOD / 2) clk = ~clk;

    annex_cache dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .stat_main_hit(stat_main_hit), .stat_annex_hit(stat_annex_hit),
        .stat_swap(stat_swap), .stat_miss(stat_miss)
    );

    typedef struct {
        int kind;
        logic [LINE_W-1:0] data;
        int lat;
        int acc;
        string req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit busy_bad = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [LINE_W-1:0] line_pattern(input logic [31:0] la);
        logic [LINE_W-1:0] v;
        for (int i = 0; i < LINE_W / 32; i++) v[i*32 +: 32] = {la[23:0], 8'(i)};
        return v;
    endfunction

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // memory model
    initial forever begin
        @(negedge clk);
        if (!rst && mem_req_valid && !mem_rsp_valid) begin
            logic [31:0] a;
            a = mem_req_addr;
            chk(a[4:0] == 5'd0, "R9", "refill address alignment", LINE_W'(a[4:0]), '0);
            repeat (MEM_LAT - 1) @(negedge clk);
            mem_rsp_data  = line_pattern(a >> 5);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
    end

    // monitor
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "response with nothing pending", 1, 0);
                end else begin
                    exp_t e;
                    int k;
                    e = sb.pop_front();
                    case ({stat_main_hit, stat_annex_hit, stat_swap, stat_miss})
                        4'b1000: k = K_MAIN;
                        4'b0100: k = K_ANNEX;
                        4'b0010: k = K_SWAP;
                        4'b0001: k = K_MISS;
                        default: k = -1;
                    endcase
                    chk(k == e.kind, e.req, "status path", LINE_W'(k), LINE_W'(e.kind));
                    chk(rsp_data == e.data, e.req, "line data", rsp_data, e.data);
                    chk(cyc - e.acc == e.lat, e.req, "latency",
                        LINE_W'(cyc - e.acc), LINE_W'(e.lat));
                    chk(!busy_bad, "R8", "ready low while busy", LINE_W'(busy_bad), 0);
                    busy_bad = 1'b0;
                end
            end else if (sb.size() > 0 && req_ready) begin
                busy_bad = 1'b1;
            end
        end
    end

    task automatic fetch(input int line, input int kind, input string r);
        exp_t e;
        @(negedge clk);
        req_addr  = (32'(line) << 5) | 32'd12;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        e.kind = kind;
        e.data = line_pattern(32'(line));
        e.lat  = (kind == K_MAIN) ? 1 : (kind == K_ANNEX) ? 2 : (kind == K_SWAP) ? 3 : MEM_LAT + 1;
        e.acc  = cyc;
        e.req  = r;
        sb.push_back(e);
        req_valid = 1'b0;
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        chk(req_ready == 1'b1, "R10", "ready in reset", LINE_W'(req_ready), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", LINE_W'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10", "no response after reset", LINE_W'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R10", "no refill after reset", LINE_W'(mem_req_valid), 0);
        chk({stat_main_hit, stat_annex_hit, stat_swap, stat_miss} == 4'b0, "R10",
            "strobes after reset",
            LINE_W'({stat_main_hit, stat_annex_hit, stat_swap, stat_miss}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // priority paths on main index 0 / annex set 0
        do_reset();
        fetch(0,  K_MISS,  "R2");   // cold: fill main
        fetch(0,  K_MAIN,  "R1");
        fetch(16, K_MISS,  "R3");   // conflict: fill annex p1
        fetch(0,  K_MAIN,  "R1");   // main p1
        fetch(16, K_ANNEX, "R4");   // main p1 -> direct read
        fetch(16, K_SWAP,  "R6");   // main p0, annex p1
        fetch(16, K_MAIN,  "R6");   // promoted line in main
        fetch(0,  K_ANNEX, "R6");   // displaced line in annex
        fetch(0,  K_SWAP,  "R6");
        fetch(32, K_MISS,  "R3");   // annex fill, main p0
        fetch(16, K_ANNEX, "R5");   // main p0, annex p0
        fetch(16, K_SWAP,  "R6");

        // swap straight after fill
        do_reset();
        fetch(0,  K_MISS,  "R2");
        fetch(16, K_MISS,  "R3");
        fetch(16, K_SWAP,  "R3");

        // eviction order in annex set 0
        do_reset();
        fetch(0,  K_MISS,  "R2");
        fetch(16, K_MISS,  "R7");
        fetch(0,  K_MAIN,  "R1");
        fetch(32, K_MISS,  "R7");
        fetch(0,  K_MAIN,  "R1");
        fetch(48, K_MISS,  "R7");
        fetch(0,  K_MAIN,  "R1");
        fetch(64, K_MISS,  "R7");
        fetch(0,  K_MAIN,  "R1");
        fetch(16, K_ANNEX, "R4");
        fetch(0,  K_MAIN,  "R1");
        fetch(80, K_MISS,  "R7");   // evicts 32
        fetch(0,  K_MAIN,  "R1");
        fetch(16, K_ANNEX, "R7");   // recently used: kept
        fetch(0,  K_MAIN,  "R1");
        fetch(32, K_MISS,  "R7");   // was evicted
        fetch(0,  K_MAIN,  "R1");
        fetch(64, K_ANNEX, "R7");   // kept

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule